// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block runs the front end of every instruction in a small 16-bit accumulator machine. A sequence counter steps through the timing states T0, T1, T2 and so on, and a decoder expands it into one-hot timing lines. In the first three states the block fetches an instruction word from memory, advances the program counter and splits the word into an indirect flag, an opcode and a 12-bit address. The opcode is expanded into eight one-hot decode lines.

In state T3 the block places the instruction in one of four classes. A memory-reference instruction with a direct address continues at T4 and leaves its address in the address register. A memory-reference instruction with an indirect address does one more memory read and replaces the address register with the low bits of the word it reads, then continues at T4. A register-reference or input-output instruction is flagged for the execution logic, which acts on that same edge. The sequence then returns to T0. Execution logic outside the block ends a memory-reference instruction by pulsing a clear input to the counter.

Top module: `icyc_seq`

## Requirements
- R1: While the synchronous active-low reset is applied, the step counter is zero (only timing line 0 is high), the program counter takes the value of parameter RESET_PC, the address and instruction registers are zero and no class output is high.
- R2: On every rising edge out of reset the step counter either goes up by one, wrapping from the last state to state 0, or goes to 0. It never holds. Exactly one timing line is high at any time.
- R3: Decode line k (bits 0 to 7 of `d_sig`) is high exactly when instruction bits 14:12 equal k. Exactly one line is high. Line 7 marks a register-reference or input-output instruction, and lines 0 to 6 mark memory-reference instructions.
- R4: In state 0 the address register loads the program counter. In state 1 the block reads memory at the address register, loads the word into the instruction register and increments the program counter. In state 2 the address register loads instruction bits 11:0 and the indirect flag loads instruction bit 15.
- R5: In state 3, with decode line 7 low and the indirect flag set, the block issues a memory read at the address register, loads the low 12 bits of the returned word into the address register, raises `cls_mem_ind` and goes to state 4.
- R6: In state 3, with decode line 7 low and the indirect flag clear, the block raises `cls_mem_dir`, issues no memory read, leaves the address register unchanged and goes to state 4.
- R7: In state 3, with decode line 7 high, the block raises `cls_reg` when the indirect flag is clear or `cls_io` when it is set, and the step counter goes to 0 on that edge.
- R8: When `exec_clr` is high at an edge, the step counter goes to 0 whatever the state, overriding the increment.
- R9: Class outputs are high only during state 3, and exactly one of them is high in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_clr | input | 1 | Request from the execution logic to return the step counter to 0 |
| mem_rdata | input | 16 | Memory word at `mem_addr`, valid in the same cycle |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 12 | Memory address, taken from the address register |
| t_sig | output | 16 | One-hot timing lines T0 to T15 |
| d_sig | output | 8 | One-hot opcode decode lines D0 to D7 |
| ind_flag | output | 1 | Latched indirect flag (instruction bit 15) |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| ir_q | output | 16 | Instruction register |
| ar_ld | output | 1 | Address register load strobe |
| pc_inc | output | 1 | Program counter increment strobe |
| ir_ld | output | 1 | Instruction register load strobe |
| cls_mem_dir | output | 1 | Memory-reference, direct address, state 3 |
| cls_mem_ind | output | 1 | Memory-reference, indirect address, state 3 |
| cls_reg | output | 1 | Register-reference, state 3 |
| cls_io | output | 1 | Input-output, state 3 |

## Verification
The bench uses a 16-bit word, a 12-bit address, a 3-bit opcode and a 4-bit step counter, so the program can use all eight decode lines. A memory-reference instruction that the bench never clears runs through T15 and wraps to T0. RESET_PC is set to 0x010, so the copy of the program counter into the address register in state 0 is not confused with the reset value. A clear pulse in state 1 shows that the counter returns to 0 early while the fetch register updates still take effect.

// File: rtl/icyc_pkg.sv
// Package: shared types for the instruction cycle sequencer.
// Assumes the class encoding below is used only inside this block.
package icyc_pkg;

    // Instruction class settled at timing state 3.
    typedef enum logic [1:0] {
        CLS_MEM_DIR = 2'd0,
        CLS_MEM_IND = 2'd1,
        CLS_REG     = 2'd2,
        CLS_IO      = 2'd3
    } icyc_class_e;

    localparam int CLS_COUNT = 4;

endpackage

// File: rtl/icyc_step_counter.sv
// Step counter with one-hot timing decoder.
// Increments every edge, or clears when clr is high. Wraps naturally.
// Assumes a synchronous active-low reset.
module icyc_step_counter #(
    parameter int SC_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    output logic [(1<<SC_W)-1:0]  t_sig
);
    localparam int NUM_T = 1 << SC_W;

    logic [SC_W-1:0] sc_q;

    // Advance or clear the step count on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   sc_q <= '0;
        else if (clr) sc_q <= '0;
        else          sc_q <= sc_q + 1'b1;
    end

    // One timing line per counter value.
    for (genvar k = 0; k < NUM_T; k++) begin : g_tdec
        assign t_sig[k] = (sc_q == SC_W'(k));
    end

    p_step_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sc_q == '0) || (sc_q == SC_W'($past(sc_q) + 1'b1))));

    p_t_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(t_sig) == 1);

endmodule

// File: rtl/icyc_op_decoder.sv
// Opcode decoder: expands an OP_W-bit opcode into one-hot lines.
// Purely combinational; assumes the opcode is a known value.
module icyc_op_decoder #(
    parameter int OP_W = 3
) (
    input  logic [OP_W-1:0]       opcode,
    output logic [(1<<OP_W)-1:0]  d_sig
);
    localparam int NUM_D = 1 << OP_W;

    // One decode line per opcode value.
    for (genvar k = 0; k < NUM_D; k++) begin : g_ddec
        assign d_sig[k] = (opcode == OP_W'(k));
    end

endmodule

// File: rtl/icyc_class_ctl.sv
// Class control: at timing state 3, picks one of four instruction classes
// from the top decode line and the indirect flag, and requests either an
// indirect read or a counter clear. Assumes t3 is high for one cycle only.
module icyc_class_ctl
    import icyc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  t3,
    input  logic                  d_top,
    input  logic                  ind,
    output logic [CLS_COUNT-1:0]  cls_hot,
    output logic                  ind_rd,
    output logic                  seq_clr
);
    icyc_class_e cls_sel;

    // Choose the class from the top decode line and the indirect flag.
    always_comb begin
        if (d_top) cls_sel = ind ? CLS_IO : CLS_REG;
        else       cls_sel = ind ? CLS_MEM_IND : CLS_MEM_DIR;
    end

    // One-hot class strobes, qualified by state 3.
    for (genvar c = 0; c < CLS_COUNT; c++) begin : g_cls
        assign cls_hot[c] = t3 && (cls_sel == icyc_class_e'(2'(c)));
    end

    // Indirect read and early return requests.
    assign ind_rd  = t3 && !d_top && ind;
    assign seq_clr = t3 && d_top;

    p_cls_only_t3_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|cls_hot) |-> t3);

    p_cls_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        t3 |-> ($countones(cls_hot) == 1));

endmodule

// File: rtl/icyc_seq.sv
// Instruction cycle timing sequencer (top).
// Holds the address, program counter, instruction and indirect-flag
// registers. Fetches in states 0-2, classifies in state 3, performs the
// indirect address read, and hands over to execution. Assumes
// DATA_W == ADDR_W + OP_W + 1, SC_W >= 3, and memory reads return data in the
// same cycle.
module icyc_seq
    import icyc_pkg::*;
#(
    parameter int               DATA_W   = 16,
    parameter int               ADDR_W   = 12,
    parameter int               OP_W     = 3,
    parameter int               SC_W     = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  exec_clr,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  mem_rd,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [(1<<SC_W)-1:0]  t_sig,
    output logic [(1<<OP_W)-1:0]  d_sig,
    output logic                  ind_flag,
    output logic [ADDR_W-1:0]     ar_q,
    output logic [ADDR_W-1:0]     pc_q,
    output logic [DATA_W-1:0]     ir_q,
    output logic                  ar_ld,
    output logic                  pc_inc,
    output logic                  ir_ld,
    output logic                  cls_mem_dir,
    output logic                  cls_mem_ind,
    output logic                  cls_reg,
    output logic                  cls_io
);
    localparam int NUM_D  = 1 << OP_W;
    localparam int OP_LSB = ADDR_W;
    localparam int I_POS  = ADDR_W + OP_W;

    logic [CLS_COUNT-1:0] cls_hot;
    logic                 ind_rd;
    logic                 seq_clr;
    logic                 ind_q;
    logic [ADDR_W-1:0]    ar_next;

    icyc_step_counter #(.SC_W(SC_W)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (exec_clr | seq_clr),
        .t_sig (t_sig)
    );

    icyc_op_decoder #(.OP_W(OP_W)) u_opdec (
        .opcode (ir_q[OP_LSB +: OP_W]),
        .d_sig  (d_sig)
    );

    icyc_class_ctl u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .t3      (t_sig[3]),
        .d_top   (d_sig[NUM_D-1]),
        .ind     (ind_q),
        .cls_hot (cls_hot),
        .ind_rd  (ind_rd),
        .seq_clr (seq_clr)
    );

    // Register strobes derived from the timing lines.
    assign ar_ld  = t_sig[0] | t_sig[2] | ind_rd;
    assign pc_inc = t_sig[1];
    assign ir_ld  = t_sig[1];
    assign mem_rd = t_sig[1] | ind_rd;
    assign mem_addr = ar_q;

    // Source for the address register in each loading state.
    always_comb begin
        if (t_sig[0])      ar_next = pc_q;
        else if (t_sig[2]) ar_next = ir_q[ADDR_W-1:0];
        else               ar_next = mem_rdata[ADDR_W-1:0];
    end

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n)     ar_q <= '0;
        else if (ar_ld) ar_q <= ar_next;
    end

    // Program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= RESET_PC;
        else if (pc_inc) pc_q <= pc_q + 1'b1;
    end

    // Instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_ld) ir_q <= mem_rdata;
    end

    // Indirect flag, captured during decode.
    always_ff @(posedge clk) begin
        if (!rst_n)        ind_q <= 1'b0;
        else if (t_sig[2]) ind_q <= ir_q[I_POS];
    end

    assign ind_flag    = ind_q;
    assign cls_mem_dir = cls_hot[CLS_MEM_DIR];
    assign cls_mem_ind = cls_hot[CLS_MEM_IND];
    assign cls_reg     = cls_hot[CLS_REG];
    assign cls_io      = cls_hot[CLS_IO];

    p_d_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(d_sig) == 1);

    p_fetch_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        t_sig[1] |-> (mem_rd && (mem_addr == pc_q)));

    p_ir_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        t_sig[1] |=> (ir_q == $past(mem_rdata)));

    p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        t_sig[1] |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

    p_ind_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sig[3] && !d_sig[NUM_D-1] && ind_q && !exec_clr)
            |=> ((ar_q == $past(mem_rdata[ADDR_W-1:0])) && t_sig[4]));

    p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sig[3] && !d_sig[NUM_D-1] && !ind_q && !exec_clr)
            |=> ((ar_q == $past(ar_q)) && t_sig[4]));

    p_rr_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sig[3] && d_sig[NUM_D-1]) |=> t_sig[0]);

    p_ext_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_clr |=> t_sig[0]);

endmodule

// File: tb/icyc_seq_test.sv
// Scoreboard bench for icyc_seq: a driver task loads the program and
// pushes expected class results; a monitor pops and compares at state 3.
module icyc_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_clr;
    logic [15:0] mem_rdata;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [15:0] t_sig;
    logic [7:0]  d_sig;
    logic        ind_flag;
    logic [11:0] ar_q, pc_q;
    logic [15:0] ir_q;
    logic        ar_ld, pc_inc, ir_ld;
    logic        cls_mem_dir, cls_mem_ind, cls_reg, cls_io;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [0:255];

    typedef struct {
        logic [1:0]  cls;    // 0 dir, 1 ind, 2 reg, 3 io
        logic [15:0] word;
        logic [11:0] pc_after;
        logic [11:0] ar_after;
        logic        to_t0;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    // End memory-reference instructions at T4, except the wrap case (0x019)
    // which runs freely, and abort the instruction at 0x01B in state 1.
    assign exec_clr = (t_sig[4] && pc_q != 12'h01A) ||
                      (t_sig[1] && pc_q == 12'h01B);

    icyc_seq #(
        .DATA_W(16), .ADDR_W(12), .OP_W(3), .SC_W(4), .RESET_PC(12'h010)
    ) uut (
        .clk(clk), .rst_n(rst_n), .exec_clr(exec_clr), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .t_sig(t_sig), .d_sig(d_sig),
        .ind_flag(ind_flag), .ar_q(ar_q), .pc_q(pc_q), .ir_q(ir_q),
        .ar_ld(ar_ld), .pc_inc(pc_inc), .ir_ld(ir_ld),
        .cls_mem_dir(cls_mem_dir), .cls_mem_ind(cls_mem_ind),
        .cls_reg(cls_reg), .cls_io(cls_io)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: place an instruction (and its pointer word) and push expectation.
    task automatic put_instr(input logic [11:0] addr, input logic [15:0] word,
                             input logic [15:0] ptr);
        exp_t e;
        mem[addr[7:0]] = word;
        e.word     = word;
        e.pc_after = addr + 12'd1;
        if (word[14:12] == 3'b111) begin
            e.cls      = word[15] ? 2'd3 : 2'd2;
            e.ar_after = word[11:0];
            e.to_t0    = 1'b1;
        end else if (word[15]) begin
            mem[word[7:0]] = ptr;
            e.cls      = 2'd1;
            e.ar_after = ptr[11:0];
            e.to_t0    = 1'b0;
        end else begin
            e.cls      = 2'd0;
            e.ar_after = word[11:0];
            e.to_t0    = 1'b0;
        end
        q.push_back(e);
    endtask

    // Monitor: compare class, decode and register results at state 3.
    exp_t cur;
    bit   pend = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                pend = 1'b0;
                chk(ar_q == cur.ar_after, "R5/R6 ar after T3", ar_q, cur.ar_after);
                chk(t_sig == (cur.to_t0 ? 16'h0001 : 16'h0010),
                    cur.to_t0 ? "R7 return to T0" : "R6 continue T4",
                    t_sig, cur.to_t0 ? 16'h0001 : 16'h0010);
            end else if (t_sig[1]) begin
                chk(mem_rd && mem_addr == pc_q && ir_ld && pc_inc,
                    "R4 fetch read at PC", {mem_rd, ir_ld, pc_inc, mem_addr}, pc_q);
            end else if (t_sig[3] && q.size() > 0) begin
                cur = q.pop_front();
                chk({cls_io, cls_reg, cls_mem_ind, cls_mem_dir} == (4'b1 << cur.cls),
                    "R9 class strobe",
                    {cls_io, cls_reg, cls_mem_ind, cls_mem_dir}, 4'b1 << cur.cls);
                chk(d_sig == (8'b1 << cur.word[14:12]), "R3 decode line",
                    d_sig, 8'b1 << cur.word[14:12]);
                chk(ir_q == cur.word && pc_q == cur.pc_after, "R4 IR and PC",
                    {ir_q, pc_q}, {cur.word, cur.pc_after});
                chk(ar_q == cur.word[11:0] && ind_flag == cur.word[15],
                    "R4 decode AR and I", {ind_flag, ar_q}, {cur.word[15], cur.word[11:0]});
                chk(mem_rd == (cur.cls == 2'd1), "R5 indirect read request",
                    mem_rd, cur.cls == 2'd1);
                pend = 1'b1;
            end
        end
    end

    // Step monitor: each edge either rotates the timing line or returns to T0.
    logic [15:0] prev_t;
    bit          have_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (have_prev)
                chk(t_sig == {prev_t[14:0], prev_t[15]} || t_sig == 16'h0001,
                    "R2 step advance or clear", t_sig, {prev_t[14:0], prev_t[15]});
            prev_t    = t_sig;
            have_prev = 1'b1;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        put_instr(12'h010, 16'h00A5, 16'h0000);
        put_instr(12'h011, 16'hA030, 16'hF123);
        put_instr(12'h012, 16'h7800, 16'h0000);
        put_instr(12'h013, 16'hF400, 16'h0000);
        put_instr(12'h014, 16'hE040, 16'h5FFF);
        put_instr(12'h015, 16'h5ABC, 16'h0000);
        put_instr(12'h016, 16'h1001, 16'h0000);
        put_instr(12'h017, 16'hB050, 16'h0077);
        put_instr(12'h018, 16'h4002, 16'h0000);
        put_instr(12'h019, 16'h2003, 16'h0000);
        put_instr(12'h01A, 16'hF001, 16'h0000);
        mem[8'h1B] = 16'h7FFF;  // aborted in state 1, never classified
        put_instr(12'h01C, 16'h8060, 16'hABCD);
        put_instr(12'h01D, 16'h7002, 16'h0000);

        // R1 reset state.
        repeat (3) @(negedge clk);
        chk(t_sig == 16'h0001, "R1 reset step", t_sig, 16'h0001);
        chk(pc_q == 12'h010 && ar_q == 12'h000 && ir_q == 16'h0000,
            "R1 reset registers", {pc_q, ar_q}, {12'h010, 12'h000});
        chk({cls_io, cls_reg, cls_mem_ind, cls_mem_dir} == 4'b0,
            "R1 reset class", {cls_io, cls_reg, cls_mem_ind, cls_mem_dir}, 0);
        rst_n = 1'b1;

        // R2 wrap: the instruction at 0x019 runs to T15 and wraps.
        @(negedge clk);
        while (!t_sig[15]) @(negedge clk);
        @(negedge clk);
        chk(t_sig == 16'h0001 && pc_q == 12'h01A, "R2 wrap T15 to T0",
            {t_sig, pc_q}, {16'h0001, 12'h01A});

        // R8 early clear in state 1: IR/PC still update, counter returns to 0.
        while (!(t_sig[1] && pc_q == 12'h01B)) @(negedge clk);
        @(negedge clk);
        chk(t_sig == 16'h0001, "R8 clear at T1", t_sig, 16'h0001);
        chk(pc_q == 12'h01C && ir_q == 16'h7FFF, "R8 fetch effects kept",
            {pc_q, ir_q}, {12'h01C, 16'h7FFF});

        while (q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule